// File: doc/BRIEF.md
# VT Circuit-Emulation Packetizer

This block turns the byte stream of a single virtual tributary into fixed-size circuit-emulation packets. The tributary arrives as repeating multiframes of four SPE quarters. The first byte of every quarter is a VT overhead byte, one of V1 to V4. That byte is dropped. Every other byte is collected into a packet payload whose length is set by `cfgPayload`. Once a payload is complete, the block emits a 32-bit control word and then the payload bytes.

The control word is sent most significant byte first. Its layout is: bit 31 extension (always 0), bit 30 remote-defect, bit 29 unequipped, bit 28 negative justification, bit 27 positive justification, bits 26:16 structure pointer, bits 15:0 sequence number. The structure pointer gives the payload offset of the V5 byte, counted from 0 at the first byte after the control word. It reads 0x1FF when the packet holds no V5 byte.

Justification flags are latched once per multiframe, at that multiframe's first overhead byte. They are reported on every packet that carries a payload byte of that multiframe. Setting both flags signals a tributary alarm. Two payload banks let one packet fill while the previous one drains.

Top module: `vt_packetizer`

## Requirements
- R1: A byte presented with `inSpeFirst`=1 is an overhead byte and never appears in any packet payload.
- R2: Each packet is exactly 4 control-word bytes followed by `cfgPayload` payload bytes, sent on consecutive cycles. `outSop` marks the first control-word byte and `outEop` marks the last payload byte.
- R3: When a packet holds a payload byte that was presented with `inV5`=1, bits 26:16 carry that byte's zero-based offset within the payload.
- R4: When a packet holds no V5 byte, bits 26:16 read 0x1FF.
- R5: Bit 28 (bit 27) is the OR of `inNeg` (`inPos`) as latched at the start (`inSpeFirst`=1, `inSpeIdx`=0) of every multiframe that contributes a payload byte to the packet. A multiframe flagged with both marks both bits.
- R6: The sequence field (bits 15:0) is 0 in the first packet after reset and rises by one per packet, modulo 2^16.
- R7: Bit 31 is always 0. Bit 30 equals `rdiIn` at the cycle the last payload byte of the packet is accepted.
- R8: If `adminDown` is high when the last payload byte is accepted, bit 29 is 1 and every payload byte of that packet is sent as 0x00. Otherwise bit 29 is 0.
- R9: When the packet is not unequipped, the payload bytes are the accepted non-overhead bytes, in arrival order and unchanged.
- R10: While `rst_n` is low, `outValid`, `outSop` and `outEop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid |
| inByte | input | 8 | Tributary byte |
| inSpeFirst | input | 1 | Byte is the overhead byte that opens an SPE quarter |
| inSpeIdx | input | 2 | SPE index within the multiframe (0 to 3) |
| inV5 | input | 1 | Byte is the V5 byte |
| inNeg | input | 1 | Negative justification for this multiframe, read at its start |
| inPos | input | 1 | Positive justification for this multiframe, read at its start |
| rdiIn | input | 1 | Remote defect to report |
| adminDown | input | 1 | Send unequipped packets |
| cfgPayload | input | 9 | Payload bytes per packet (static while running) |
| outValid | output | 1 | Output byte valid |
| outByte | output | 8 | Output byte |
| outSop | output | 1 | First byte of a packet |
| outEop | output | 1 | Last byte of a packet |

## Verification
The bench keeps the default bank depth of 432 bytes. It feeds multiframes with VT1.5 geometry (27-byte quarters) and VT2 geometry (36-byte quarters). Payload sizes of 104, 26, 35, 13 and 140 bytes are used. These sizes produce packets that contain exactly one V5 byte, packets that contain none, packets that straddle multiframe borders, and sizes that do not divide the multiframe. The V5 offsets and the justification and alarm flags vary from one multiframe to the next. Every emitted byte is compared with a model built only from the stream the bench sent.

// File: rtl/vtpk_pkg.sv
package vtpk_pkg;

  localparam int PTR_W = 11;
  localparam int SEQ_W = 16;
  localparam logic [PTR_W-1:0] PTR_NONE = 11'h1FF;

  // 32-bit control word, most significant field first.
  typedef struct packed {
    logic             ext;
    logic             rdi;
    logic             uneq;
    logic             negJ;
    logic             posJ;
    logic [PTR_W-1:0] ptr;
    logic [SEQ_W-1:0] seq;
  } vtHdr_t;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic       wrEn;
    logic       wrBank;
    logic       outValid;
    logic       outSop;
    logic       outEop;
    logic       hdrSel;
    logic [1:0] hdrIdx;
    logic       rdBank;
    logic       zeroFill;
  } vtpkStb_t;

endpackage

// File: rtl/vtpk_ctrl.sv
module vtpk_ctrl
  import vtpk_pkg::*;
#(
  parameter int MAX_PAYLOAD = 432,
  localparam int AW    = $clog2(MAX_PAYLOAD),
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1),
  localparam int CNT_W = $clog2(MAX_PAYLOAD + 5)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             inSpeFirst,
  input  logic [1:0]       inSpeIdx,
  input  logic             inV5,
  input  logic             inNeg,
  input  logic             inPos,
  input  logic             rdiIn,
  input  logic             adminDown,
  input  logic [LEN_W-1:0] cfgPayload,
  output vtpkStb_t         stb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output vtHdr_t           hdrWord
);

  logic [LEN_W-1:0] fillCnt;
  logic             curN, curP, accN, accP, v5Seen;
  logic [PTR_W-1:0] ptrReg;
  logic [SEQ_W-1:0] seqCnt;
  logic             wrBank, rdBank, active;
  logic [1:0]       bankFull, setMask, clrMask;
  vtHdr_t           hdrBank [2];
  vtHdr_t           hdrNew;
  logic [CNT_W-1:0] outCnt;
  logic             payloadByte, mfStart, closeByte, lastOut;

  assign payloadByte = inValid && !inSpeFirst;
  assign mfStart     = inValid && inSpeFirst && (inSpeIdx == 2'd0);
  assign closeByte   = payloadByte && (fillCnt == LEN_W'(cfgPayload - 1'b1));
  assign lastOut     = active && (outCnt == CNT_W'(cfgPayload) + CNT_W'(3));

  always_comb begin
    hdrNew.ext  = 1'b0;
    hdrNew.rdi  = rdiIn;
    hdrNew.uneq = adminDown;
    hdrNew.negJ = accN | curN;
    hdrNew.posJ = accP | curP;
    hdrNew.ptr  = v5Seen ? ptrReg : (inV5 ? PTR_W'(fillCnt) : PTR_NONE);
    hdrNew.seq  = seqCnt;
  end

  // Justification flags of the multiframe currently arriving.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curN <= 1'b0;
      curP <= 1'b0;
    end else if (mfStart) begin
      curN <= inNeg;
      curP <= inPos;
    end
  end

  // Fill side: payload counting, pointer capture, flag accumulation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fillCnt    <= '0;
      accN       <= 1'b0;
      accP       <= 1'b0;
      v5Seen     <= 1'b0;
      ptrReg     <= '0;
      seqCnt     <= '0;
      wrBank     <= 1'b0;
      hdrBank[0] <= '0;
      hdrBank[1] <= '0;
    end else if (payloadByte) begin
      if (closeByte) begin
        fillCnt         <= '0;
        accN            <= 1'b0;
        accP            <= 1'b0;
        v5Seen          <= 1'b0;
        hdrBank[wrBank] <= hdrNew;
        wrBank          <= ~wrBank;
        seqCnt          <= seqCnt + 1'b1;
      end else begin
        fillCnt <= fillCnt + 1'b1;
        accN    <= accN | curN;
        accP    <= accP | curP;
        if (inV5 && !v5Seen) begin
          v5Seen <= 1'b1;
          ptrReg <= PTR_W'(fillCnt);
        end
      end
    end
  end

  always_comb begin
    setMask = 2'b00;
    clrMask = 2'b00;
    if (closeByte) setMask[wrBank] = 1'b1;
    if (lastOut)   clrMask[rdBank] = 1'b1;
  end

  // Drain side: walks header then payload of the oldest full bank.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bankFull <= 2'b00;
      active   <= 1'b0;
      rdBank   <= 1'b0;
      outCnt   <= '0;
    end else begin
      bankFull <= (bankFull | setMask) & ~clrMask;
      if (!active) begin
        if (bankFull[rdBank]) begin
          active <= 1'b1;
          outCnt <= '0;
        end
      end else if (lastOut) begin
        active <= 1'b0;
        rdBank <= ~rdBank;
      end else begin
        outCnt <= outCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.wrEn     = payloadByte;
    stb.wrBank   = wrBank;
    stb.outValid = active;
    stb.outSop   = active && (outCnt == '0);
    stb.outEop   = lastOut;
    stb.hdrSel   = outCnt < CNT_W'(4);
    stb.hdrIdx   = outCnt[1:0];
    stb.rdBank   = rdBank;
    stb.zeroFill = hdrBank[rdBank].uneq;
  end

  assign wrAddr  = AW'(fillCnt);
  assign rdAddr  = AW'(outCnt - CNT_W'(4));
  assign hdrWord = hdrBank[rdBank];

endmodule

// File: rtl/vtpk_datapath.sv
module vtpk_datapath
  import vtpk_pkg::*;
#(
  parameter int MAX_PAYLOAD = 432,
  localparam int AW = $clog2(MAX_PAYLOAD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    inByte,
  input  vtpkStb_t      stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  vtHdr_t        hdrWord,
  output logic          outValid,
  output logic [7:0]    outByte,
  output logic          outSop,
  output logic          outEop
);

  logic [7:0]  mem [2][MAX_PAYLOAD];
  logic [31:0] hdrFlat;
  logic [7:0]  hdrByte, nextByte;

  assign hdrFlat = hdrWord;

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[stb.wrBank][wrAddr] <= inByte;
  end

  always_comb begin
    case (stb.hdrIdx)
      2'd0:    hdrByte = hdrFlat[31:24];
      2'd1:    hdrByte = hdrFlat[23:16];
      2'd2:    hdrByte = hdrFlat[15:8];
      default: hdrByte = hdrFlat[7:0];
    endcase
    if (stb.hdrSel)        nextByte = hdrByte;
    else if (stb.zeroFill) nextByte = 8'h00;
    else                   nextByte = mem[stb.rdBank][rdAddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outByte  <= '0;
    end else begin
      outValid <= stb.outValid;
      outSop   <= stb.outSop;
      outEop   <= stb.outEop;
      outByte  <= stb.outValid ? nextByte : 8'h00;
    end
  end

endmodule

// File: rtl/vt_packetizer.sv
module vt_packetizer
  import vtpk_pkg::*;
#(
  parameter int MAX_PAYLOAD = 432,
  localparam int AW    = $clog2(MAX_PAYLOAD),
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [7:0]       inByte,
  input  logic             inSpeFirst,
  input  logic [1:0]       inSpeIdx,
  input  logic             inV5,
  input  logic             inNeg,
  input  logic             inPos,
  input  logic             rdiIn,
  input  logic             adminDown,
  input  logic [LEN_W-1:0] cfgPayload,
  output logic             outValid,
  output logic [7:0]       outByte,
  output logic             outSop,
  output logic             outEop
);

  vtpkStb_t      stb;
  logic [AW-1:0] wrAddr, rdAddr;
  vtHdr_t        hdrWord;

  vtpk_ctrl #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSpeFirst(inSpeFirst),
    .inSpeIdx(inSpeIdx), .inV5(inV5), .inNeg(inNeg), .inPos(inPos),
    .rdiIn(rdiIn), .adminDown(adminDown), .cfgPayload(cfgPayload),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .hdrWord(hdrWord)
  );

  vtpk_datapath #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_dp (
    .clk(clk), .rst_n(rst_n), .inByte(inByte), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .hdrWord(hdrWord),
    .outValid(outValid), .outByte(outByte), .outSop(outSop), .outEop(outEop)
  );

endmodule

// File: rtl/vt_packetizer_chk.sv
module vt_packetizer_chk #(
  parameter int MAX_PAYLOAD = 432,
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1),
  localparam int POS_W = $clog2(MAX_PAYLOAD + 5)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] cfgPayload,
  input logic             outValid,
  input logic [7:0]       outByte,
  input logic             outSop,
  input logic             outEop
);

  logic [POS_W-1:0] pos, curPos;
  logic [7:0]       b0, b2;
  logic [15:0]      lastSeq;
  logic             haveSeq;

  assign curPos = outSop ? '0 : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      b0      <= '0;
      b2      <= '0;
      lastSeq <= '0;
      haveSeq <= 1'b0;
    end else if (outValid) begin
      pos <= curPos + 1'b1;
      if (curPos == POS_W'(0)) b0 <= outByte;
      if (curPos == POS_W'(2)) b2 <= outByte;
      if (curPos == POS_W'(3)) begin
        lastSeq <= {b2, outByte};
        haveSeq <= 1'b1;
      end
    end
  end

  // R10: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) p_quiet_in_reset_r10: assert (!outValid && !outSop && !outEop);
  end

  p_sop_framing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outSop |-> (outValid && !outEop));

  p_eop_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outEop) |-> (curPos == POS_W'(cfgPayload) + POS_W'(3)));

  p_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outEop) |=> outValid);

  p_ext_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outSop) |-> !outByte[7]);

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && curPos == POS_W'(1)) |->
      ({b0[2:0], outByte} == 11'h1FF || {b0[2:0], outByte} < 11'(cfgPayload)));

  p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && curPos == POS_W'(3) && haveSeq) |-> ({b2, outByte} == lastSeq + 16'd1));

  p_uneq_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && curPos >= POS_W'(4) && b0[5]) |-> (outByte == 8'h00));

endmodule

bind vt_packetizer vt_packetizer_chk #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfgPayload(cfgPayload), .outValid(outValid),
  .outByte(outByte), .outSop(outSop), .outEop(outEop)
);

// File: tb/vt_packetizer_bench.sv
`timescale 1ns/1ps
module vt_packetizer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic       inSpeFirst = 1'b0;
  logic [1:0] inSpeIdx = '0;
  logic       inV5 = 1'b0;
  logic       inNeg = 1'b0;
  logic       inPos = 1'b0;
  logic       rdiIn = 1'b0;
  logic       adminDown = 1'b0;
  logic [8:0] cfgPayload = 9'd104;
  logic       outValid, outSop, outEop;
  logic [7:0] outByte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] plData [4096];
  int         plMf   [4096];
  bit         plV5   [4096];
  int         nPl;
  bit         mfN [32];
  bit         mfP [32];
  logic [7:0] oByte [4096];
  bit         oSop  [4096];
  bit         oEop  [4096];
  int         oCnt;

  always #2 clk = ~clk;

  vt_packetizer u_vt_packetizer (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inByte(inByte),
    .inSpeFirst(inSpeFirst), .inSpeIdx(inSpeIdx), .inV5(inV5),
    .inNeg(inNeg), .inPos(inPos), .rdiIn(rdiIn), .adminDown(adminDown),
    .cfgPayload(cfgPayload), .outValid(outValid), .outByte(outByte),
    .outSop(outSop), .outEop(outEop)
  );

  always @(negedge clk) begin
    if (rst_n && outValid && oCnt < 4096) begin
      oByte[oCnt] = outByte;
      oSop[oCnt]  = outSop;
      oEop[oCnt]  = outEop;
      oCnt = oCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input bit first, input logic [1:0] idx,
                          input bit v5, input bit n, input bit p);
    @(negedge clk);
    inValid = 1'b1; inByte = d; inSpeFirst = first; inSpeIdx = idx;
    inV5 = v5; inNeg = n; inPos = p;
    @(negedge clk);
    inValid = 1'b0; inSpeFirst = 1'b0; inV5 = 1'b0; inNeg = 1'b0; inPos = 1'b0;
  endtask

  task automatic runCase(input int q, input int nMf, input int pay, input bit adm, input bit rdi);
    int nPk, framingErr, payErr, ovhSeen, v5Off, pi;
    logic [31:0] hdr, expHdr;
    logic [10:0] expPtr;
    bit eN, eP;
    @(negedge clk);
    rst_n = 1'b0;
    cfgPayload = 9'(pay); adminDown = adm; rdiIn = rdi;
    repeat (3) @(negedge clk);
    chk(!outValid && !outSop && !outEop, "R10 outputs during reset", {29'd0, outValid, outSop, outEop}, 0);
    oCnt = 0; nPl = 0;
    rst_n = 1'b1;
    for (int m = 0; m < nMf; m++) begin
      mfN[m] = (m % 3 == 1) || (m == 3);
      mfP[m] = (m % 4 == 2) || (m == 3);
      v5Off  = (m * 37 + 5) % (4 * q - 4);
      pi = 0;
      for (int qi = 0; qi < 4; qi++) begin
        for (int b = 0; b < q; b++) begin
          if (b == 0) begin
            sendByte(8'hEE, 1'b1, 2'(qi), 1'b0, (qi == 0) && mfN[m], (qi == 0) && mfP[m]);
          end else begin
            plData[nPl] = 8'((m * 29 + pi * 3) % 200);
            plMf[nPl]   = m;
            plV5[nPl]   = (pi == v5Off);
            sendByte(plData[nPl], 1'b0, 2'(qi), pi == v5Off, 1'b0, 1'b0);
            nPl++;
            pi++;
          end
        end
      end
    end
    repeat (2 * (pay + 8)) @(negedge clk);

    nPk = nPl / pay;
    chk(oCnt == nPk * (pay + 4), "R2 emitted byte count", oCnt, nPk * (pay + 4));
    framingErr = 0;
    for (int i = 0; i < oCnt; i++) begin
      if (oSop[i] != ((i % (pay + 4)) == 0)) framingErr++;
      if (oEop[i] != ((i % (pay + 4)) == pay + 3)) framingErr++;
    end
    chk(framingErr == 0, "R2 sop/eop placement", framingErr, 0);

    for (int k = 0; k < nPk && (k + 1) * (pay + 4) <= oCnt; k++) begin
      int base;
      base = k * (pay + 4);
      hdr = {oByte[base], oByte[base + 1], oByte[base + 2], oByte[base + 3]};
      eN = 0; eP = 0; expPtr = 11'h1FF;
      payErr = 0; ovhSeen = 0;
      for (int i = 0; i < pay; i++) begin
        int idx;
        idx = k * pay + i;
        eN |= mfN[plMf[idx]];
        eP |= mfP[plMf[idx]];
        if (plV5[idx] && expPtr == 11'h1FF) expPtr = 11'(i);
        if (oByte[base + 4 + i] != (adm ? 8'h00 : plData[idx])) payErr++;
        if (oByte[base + 4 + i] == 8'hEE) ovhSeen++;
      end
      expHdr = {1'b0, rdi, adm, eN, eP, expPtr, 16'(k)};
      chk(hdr[31] == 1'b0, "R7 extension bit", hdr[31], 0);
      chk(hdr[30] == rdi, "R7 remote-defect bit", hdr[30], rdi);
      chk(hdr[29] == adm, "R8 unequipped bit", hdr[29], adm);
      chk(hdr[28:27] == {eN, eP}, "R5 justification bits", hdr[28:27], {eN, eP});
      if (expPtr == 11'h1FF) chk(hdr[26:16] == expPtr, "R4 no-V5 pointer", hdr[26:16], expPtr);
      else                   chk(hdr[26:16] == expPtr, "R3 V5 pointer", hdr[26:16], expPtr);
      chk(hdr[15:0] == 16'(k), "R6 sequence", hdr[15:0], k);
      chk(ovhSeen == 0, "R1 overhead byte in payload", ovhSeen, 0);
      if (adm) chk(payErr == 0, "R8 zero payload", payErr, 0);
      else     chk(payErr == 0, "R9 payload bytes", payErr, 0);
      chk(hdr == expHdr, "R3 R5 R6 R7 full word", hdr, expHdr);
    end
  endtask

  initial begin
    oCnt = 0;
    runCase(27, 6, 104, 1'b0, 1'b0);
    runCase(27, 5, 26, 1'b0, 1'b1);
    runCase(27, 6, 35, 1'b0, 1'b0);
    runCase(27, 3, 13, 1'b1, 1'b1);
    runCase(36, 4, 140, 1'b0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule